// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 4-bit CPU core and turns them into one vectored request at a time. Eleven maskable hardware sources feed seven hardware priority levels. A software write port can raise any of eight levels, including the lowest level, which has no hardware source. The block keeps a pending bit and an in-service bit for each level. It offers the core the vector of the highest eligible pending level. It never offers a level that is at or below a level already being serviced.

The core takes a request through a valid/ready handshake on the vector output. A transfer happens on a clock edge where both `irq_valid` and `irq_ready` are high. That transfer is the acknowledge. A one-cycle `reti` pulse tells the block that the deepest active service routine has finished.

Back-pressure rules:
- While `irq_ready` is low, the offer stays up and the vector holds, unless a strictly higher level becomes pending or `gie` drops.
- The software write port never stalls. Its `sw_wr_ready` output is constantly high, so each cycle with `sw_wr_valid` high is one accepted write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Levels are numbered 0 to 7 and a higher number means higher priority; when several levels are eligible, the highest is offered.
- R2: The vector for level L is (L+1)×040h for L = 0..6, and 1E0h for level 7. In hex: 040, 080, 0C0, 100, 140, 180, 1C0, 1E0.
- R3: The source-to-level map is as follows, with `src_mask` bit index = source number:
  - src 0 (edge on pin 0) → level 1
  - src 1 (edge on pin 1) → level 1
  - src 2 (`tmr1_evt`) → level 2
  - src 3 (`ser_evt`, or an edge on pin 2 or pin 3) → level 3
  - src 4 (`tmr2_evt`) → level 4
  - src 5 (`tmr3_cmp1_evt`) → level 5
  - src 6 (`tmr3_cmp2_evt`) → level 5
  - src 7 (`tmr3_edge_evt`) → level 5
  - src 8 (edge on pin 4) → level 6
  - src 9 (edge on pin 5) → level 6
  - src 10 (`vmon_evt`) → level 7
- R4: When `src_mask` bit s is 1, source s never sets a pending bit.
- R5: A cycle with `sw_wr_valid` high sets pending bit k for every 1 in bit k of `sw_wr_data`. A 0 bit leaves pending bit k unchanged. `sw_wr_ready` is always 1.
- R6: Level 0 can be raised only by software. A software-raised level has the same priority and vector as a hardware-raised one.
- R7: While `irq_valid` is high and `irq_ready` is low, with no new request, no `reti` and `gie` high, the offer and its vector stay unchanged.
- R8: On acknowledge, the offered level's pending bit clears and its in-service bit sets, unless a new request for that level arrives in the same cycle.
- R9: A pending level is offered only if it is strictly higher than every level currently in service.
- R10: A `reti` pulse clears only the highest set in-service bit.
- R11: With `gie` low, `irq_valid` is low and pending bits are kept.
- R12: Pin sources pass a synchronizer and then fire on a rising or a falling edge. Event inputs set pending on each clock cycle they are high.
- R13: Reset clears every pending and in-service bit, so `irq_valid` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | 6 | Asynchronous port pins, edge-sensitive sources |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| ser_evt | input | 1 | Serial buffer full/empty pulse |
| tmr2_evt | input | 1 | Timer 2 compare/overflow pulse |
| tmr3_cmp1_evt | input | 1 | Timer 3 compare 1 pulse |
| tmr3_cmp2_evt | input | 1 | Timer 3 compare 2 pulse |
| tmr3_edge_evt | input | 1 | Timer 3 input edge pulse |
| vmon_evt | input | 1 | Voltage monitor pulse |
| src_mask | input | 11 | Per-source mask, 1 blocks the source |
| sw_wr_valid | input | 1 | Software pending write strobe |
| sw_wr_data | input | 8 | Software pending bits, one per level |
| sw_wr_ready | output | 1 | Always 1, write port never stalls |
| irq_valid | output | 1 | Request offered to the core |
| irq_vector | output | 9 | Vector address of the offered level |
| irq_ready | input | 1 | Core accepts the offer (acknowledge) |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
The hardest state to reach is nested service. In this state two levels are in service and a lower level is blocked while pending. Getting there takes a specific order of steps: acknowledge a middle level, raise a lower and an equal level, then raise and acknowledge a higher one. The stimulus does this with software writes interleaved with acknowledges. It then unwinds the nesting one `reti` at a time. After each `reti` it checks that only the blocked level's turn has come, and only when every higher in-service bit is gone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL  = 8;
  localparam int LW   = $clog2(LVL);
  localparam int NSRC = 11;
  localparam int NPIN = 6;
  localparam int VW   = 9;

  // vector of a level: steps of 040h, top level pinned at 1E0h
  function automatic logic [VW-1:0] level_vector(input logic [LW-1:0] l);
    if (l == LW'(LVL - 1)) return VW'(9'h1E0);
    return VW'((int'(l) + 1) * 64);
  endfunction

  // source number to priority level
  function automatic int src_level(input int s);
    case (s)
      0, 1:    return 1;
      2:       return 2;
      3:       return 3;
      4:       return 4;
      5, 6, 7: return 5;
      8, 9:    return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/irq_src_merge.sv
module irq_src_merge
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] mask,
  output logic [LVL-1:0]  hw_set
);
  always_comb begin
    hw_set = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (evt[s] && !mask[s]) hw_set[src_level(s)] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LVL-1:0] hw_set,
  input  logic           sw_valid,
  input  logic [LVL-1:0] sw_data,
  input  logic           clr_valid,
  input  logic [LW-1:0]  clr_lvl,
  output logic [LVL-1:0] pend_q
);
  logic [LVL-1:0] set_now;
  logic [LVL-1:0] clr_mask;

  assign set_now  = hw_set | (sw_valid ? sw_data : '0);
  assign clr_mask = clr_valid ? (LVL'(1) << clr_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= (pend_q & ~clr_mask) | set_now;
  end

  // R8: acknowledged level leaves pending unless re-raised in the same cycle
  p_ack_clears_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !set_now[clr_lvl]) |=> !pend_q[$past(clr_lvl)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LVL-1:0] pend,
  input  logic           gie,
  input  logic           ready,
  input  logic           reti,
  output logic           valid,
  output logic [VW-1:0]  vector,
  output logic           ack,
  output logic [LW-1:0]  ack_lvl
);
  logic [LVL-1:0] ins_q;
  logic [LW-1:0]  hp_lvl;
  logic [LW-1:0]  top_lvl;
  logic           hp_any;
  logic           ins_any;
  logic [LVL-1:0] ins_next;

  always_comb begin
    hp_lvl = '0;
    top_lvl = '0;
    for (int l = 0; l < LVL; l++) begin
      if (pend[l])  hp_lvl  = LW'(l);
      if (ins_q[l]) top_lvl = LW'(l);
    end
  end

  assign hp_any  = |pend;
  assign ins_any = |ins_q;
  assign valid   = gie && hp_any && (!ins_any || (hp_lvl > top_lvl));
  assign vector  = level_vector(hp_lvl);
  assign ack     = valid && ready;
  assign ack_lvl = hp_lvl;

  always_comb begin
    ins_next = ins_q;
    if (reti && ins_any) ins_next[top_lvl] = 1'b0;
    if (ack) ins_next[hp_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_q <= '0;
    else ins_q <= ins_next;
  end

  // R8: acknowledged level becomes in service
  p_ack_sets_ins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ins_q[$past(ack_lvl)]);

  // R10: a return retires exactly one in-service level
  p_reti_drops_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_any && !ack) |=> ($countones(ins_q) == $countones($past(ins_q)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie,
  input  logic [NPIN-1:0] pin_in,
  input  logic            tmr1_evt,
  input  logic            ser_evt,
  input  logic            tmr2_evt,
  input  logic            tmr3_cmp1_evt,
  input  logic            tmr3_cmp2_evt,
  input  logic            tmr3_edge_evt,
  input  logic            vmon_evt,
  input  logic [NSRC-1:0] src_mask,
  input  logic            sw_wr_valid,
  input  logic [LVL-1:0]  sw_wr_data,
  output logic            sw_wr_ready,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vector,
  input  logic            irq_ready,
  input  logic            reti
);
  logic [NPIN-1:0] pin_edge;
  logic [NSRC-1:0] evt;
  logic [LVL-1:0]  hw_set;
  logic [LVL-1:0]  pend;
  logic            ack;
  logic [LW-1:0]   ack_lvl;

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in[p]), .edge_o(pin_edge[p])
      );
    end
  endgenerate

  assign evt = {vmon_evt, pin_edge[5], pin_edge[4], tmr3_edge_evt, tmr3_cmp2_evt,
                tmr3_cmp1_evt, tmr2_evt, ser_evt | pin_edge[2] | pin_edge[3],
                tmr1_evt, pin_edge[1], pin_edge[0]};

  irq_src_merge u_merge (.evt(evt), .mask(src_mask), .hw_set(hw_set));

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_valid(sw_wr_valid),
    .sw_data(sw_wr_data), .clr_valid(ack), .clr_lvl(ack_lvl), .pend_q(pend)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .gie(gie), .ready(irq_ready),
    .reti(reti), .valid(irq_valid), .vector(irq_vector), .ack(ack), .ack_lvl(ack_lvl)
  );

  assign sw_wr_ready = 1'b1;

  // R11: no offer while the global enable is low
  p_gie_gates_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_valid);

  // R7: a stalled offer holds when nothing new arrives
  p_offer_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !sw_wr_valid && hw_set == '0 && !reti)
      |=> (!gie || (irq_valid && $stable(irq_vector))));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gie = 1'b0;
  logic [5:0] pin_in = '0;
  logic tmr1_evt = 0, ser_evt = 0, tmr2_evt = 0, tmr3_cmp1_evt = 0;
  logic tmr3_cmp2_evt = 0, tmr3_edge_evt = 0, vmon_evt = 0;
  logic [10:0] src_mask = '0;
  logic sw_wr_valid = 0;
  logic [7:0] sw_wr_data = '0;
  logic sw_wr_ready, irq_valid, irq_ready = 0, reti = 0;
  logic [8:0] irq_vector;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (.*);

  // software byte -> expected vector (R1, R2, R5, R6)
  localparam logic [16:0] TBL [10] = '{
    {8'h01, 9'h040}, {8'h02, 9'h080}, {8'h04, 9'h0C0}, {8'h08, 9'h100},
    {8'h10, 9'h140}, {8'h20, 9'h180}, {8'h40, 9'h1C0}, {8'h80, 9'h1E0},
    {8'h05, 9'h0C0}, {8'hFF, 9'h1E0}};

  // hardware stimulus k -> expected vector (R3, R12)
  localparam logic [8:0] HWV [13] = '{
    9'h0C0, 9'h100, 9'h140, 9'h180, 9'h180, 9'h180, 9'h1E0,
    9'h080, 9'h080, 9'h100, 9'h100, 9'h1C0, 9'h1C0};

  task automatic chk(input string tag, input logic ev, input logic [8:0] evec);
    n_chk++;
    if (irq_valid !== ev || (ev && irq_vector !== evec)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b vector=%h expected valid=%0b vector=%h",
               tag, irq_valid, irq_vector, ev, evec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pin_in = '0; src_mask = '0; gie = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk); sw_wr_valid = 1; sw_wr_data = d;
    @(negedge clk); sw_wr_valid = 0; sw_wr_data = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ready = 1;
    @(negedge clk); irq_ready = 0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  task automatic hw_stim(input int k);
    @(negedge clk);
    case (k)
      0: tmr1_evt = 1;  1: ser_evt = 1;  2: tmr2_evt = 1;  3: tmr3_cmp1_evt = 1;
      4: tmr3_cmp2_evt = 1;  5: tmr3_edge_evt = 1;  6: vmon_evt = 1;
      default: pin_in[k-7] = ~pin_in[k-7];
    endcase
    @(negedge clk);
    {tmr1_evt, ser_evt, tmr2_evt, tmr3_cmp1_evt, tmr3_cmp2_evt, tmr3_edge_evt, vmon_evt} = '0;
    if (k >= 7) repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R13: reset state
    do_reset();
    chk("R13 reset no offer", 0, '0);
    n_chk++;
    if (sw_wr_ready !== 1'b1) begin
      n_bad++; $display("FAIL R5 ready: actual=%0b expected=1", sw_wr_ready);
    end

    // table walk: R1 R2 R5 R6
    for (int i = 0; i < 10; i++) begin
      do_reset();
      sw_write(TBL[i][16:9]);
      chk("R2 R1 sw vector table", 1, TBL[i][8:0]);
    end

    // R3 R12: every hardware source path
    for (int k = 0; k < 13; k++) begin
      do_reset();
      hw_stim(k);
      chk("R3 R12 source map", 1, HWV[k]);
    end

    // R12 falling edge, R8 pending cleared
    do_reset();
    hw_stim(7);
    do_ack(); do_reti();
    chk("R8 pending cleared after ack", 0, '0);
    hw_stim(7);
    chk("R12 falling edge fires", 1, 9'h080);

    // R4 masking
    do_reset();
    src_mask = 11'b001_0000_0100;
    hw_stim(0); hw_stim(11);
    chk("R4 masked sources silent", 0, '0);
    hw_stim(2);
    chk("R4 unmasked still served", 1, 9'h140);
    do_ack(); do_reti();
    chk("R4 masked never pending", 0, '0);

    // R9 R10 nesting
    do_reset();
    sw_write(8'h08); chk("R9 level3 offered", 1, 9'h100);
    do_ack();
    sw_write(8'h0C); chk("R9 equal and lower blocked", 0, '0);
    sw_write(8'h20); chk("R9 higher preempts", 1, 9'h180);
    do_ack();        chk("R9 nested blocked", 0, '0);
    do_reti();       chk("R10 one level retired", 0, '0);
    do_reti();       chk("R10 unblocked highest", 1, 9'h100);

    // R9 after top level acknowledged
    do_reset();
    sw_write(8'hFF); do_ack();
    chk("R9 top in service blocks all", 0, '0);

    // R6 software preempts hardware service
    do_reset();
    hw_stim(0); do_ack();
    sw_write(8'h10);
    chk("R6 sw raised preempts", 1, 9'h140);

    // R11 global enable
    do_reset();
    gie = 0;
    sw_write(8'h02); chk("R11 gie low hides", 0, '0);
    repeat (3) @(negedge clk);
    gie = 1; #1;
    chk("R11 pending kept", 1, 9'h080);

    // R7 hold under back-pressure
    do_reset();
    sw_write(8'h10);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R7 held offer", 1, 9'h140);
    end

    // R5 zero bits do not clear
    do_reset();
    sw_write(8'h40); sw_write(8'h01);
    chk("R5 zero bits keep pending", 1, 9'h1C0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule